// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Aggregator

The block gathers 79 level-sensitive peripheral interrupt sources into one active-low processor interrupt request. The sources come in fourteen groups of fixed but unequal widths. Each group has its own pending register, which captures source levels, and its own enable mask. The enabled pending bits of a group OR down to one summary bit. Each summary bit sits at its own position in a top-level group-0 pending view, and that view has a separate enable mask. The enabled group-0 bits OR into the request, and a register drives the request onto the output.

Software uses a flat register port to read and write every register. It sets enable masks, reads pending state and clears serviced pending bits with write-one-to-clear. After reset every mask is zero, so no source can raise the request until software enables it at both levels.

Top module: `irq_group_agg`

## Requirements
- R1: Group widths for groups 1 to 14 are 1, 12, 7, 8, 3, 3, 5, 5, 5, 5, 4, 16, 4 and 1. The groups are packed into `src_i` from bit 0 upward in group order, so group 1 is bit 0 and group 2 is bits 12:1. Bit N of the group-0 pending view is 1 exactly when some bit of group N is both pending and enabled.
- R2: A group pending bit becomes 1 at the clock edge where its source is 1. It stays 1 until it is cleared. It never becomes 1 without its source being 1 at that edge.
- R3: Writing 1 to a bit of a group pending register clears that bit only if the bit's source is 0 at that edge. Writing 0 leaves the bit unchanged. A pending bit never clears without a write.
- R4: Group mask registers reset to 0. A mask bit of 1 enables its pending bit. A write loads the low W bits of the write data, where W is the group width. Bits at W and above read as 0.
- R5: The group-0 pending view at address 0 is read-only and shows the live summaries in bits 14:1. Bits 0 and 15 read as 0, and writes to address 0 have no effect.
- R6: The group-0 mask at address 1 resets to 0. Only bits 14:1 are writable, and bits 0 and 15 always read as 0.
- R7: `irq_no` is 1 in reset. After each clock edge it is 0 exactly when, before that edge, some group-0 bit was both set and enabled.
- R8: Group N pending sits at address 2N and group N mask sits at address 2N+1, for N from 1 to 14. Addresses 30 and 31 read as 0, and writes to them have no effect.
- R9: `rdata_o` depends combinationally on `addr_i` and the current register state, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 79 | Interrupt source levels, groups packed from bit 0 |
| we_i | input | 1 | Register write enable |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data |
| irq_no | output | 1 | Active-low aggregated interrupt request |

## Verification
The assertions assume that `src_i` and the write port change only away from the rising clock edge. They also assume that any pending clear or mask change comes with `we_i` in the cycle before it. The bench meets both assumptions by driving every input just after the falling edge and by making all register updates through the port. The sources are sparse random levels and include pulses of a single cycle. Clear writes are issued while the source is still high as well as after it has fallen, so that both outcomes of R3 occur.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NGRP = 14;
  localparam int DW   = 16;
  localparam int AW   = 5;
  localparam int GRP_W [1:NGRP] = '{1, 12, 7, 8, 3, 3, 5, 5, 5, 5, 4, 16, 4, 1};

  function automatic int grp_base(int n);
    int s = 0;
    for (int i = 1; i < n; i++) s += GRP_W[i];
    return s;
  endfunction

  localparam int NSRC = grp_base(NGRP + 1);
endpackage

// File: rtl/irq_grp_slice.sv
module irq_grp_slice #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         wr_pend_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o,
  output logic         sum_o
);
  logic [W-1:0] clr;

  assign clr = wr_pend_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      mask_o <= '0;
    end else begin
      // new level wins over a same-cycle clear
      pend_o <= src_i | (pend_o & ~clr);
      if (wr_mask_i) mask_o <= wdata_i;
    end
  end

  assign sum_o = |(pend_o & mask_o);
endmodule

// File: rtl/irq_root.sv
module irq_root #(
  parameter int NGRP = 14,
  parameter int DW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NGRP:1]   sum_i,
  input  logic            wr_mask_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   g0_pend_o,
  output logic [DW-1:0]   g0_mask_o,
  output logic            irq_no
);
  localparam int PADW = DW - NGRP - 1;
  localparam logic [DW-1:0] VALID = {{PADW{1'b0}}, {NGRP{1'b1}}, 1'b0};

  assign g0_pend_o = {{PADW{1'b0}}, sum_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g0_mask_o <= '0;
      irq_no    <= 1'b1;
    end else begin
      if (wr_mask_i) g0_mask_o <= wdata_i & VALID;
      irq_no <= ~|(g0_pend_o & g0_mask_o);
    end
  end
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_agg_pkg::*;
#(
  parameter int NG = NGRP,
  parameter int DATW = DW,
  parameter int ADRW = AW,
  parameter int NS = NSRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NS-1:0]   src_i,
  input  logic            we_i,
  input  logic [ADRW-1:0] addr_i,
  input  logic [DATW-1:0] wdata_i,
  output logic [DATW-1:0] rdata_o,
  output logic            irq_no
);
  logic [NS-1:0]   pend_flat;
  logic [NS-1:0]   mask_flat;
  logic [NG:1]     grp_sum;
  logic [DATW-1:0] pend_rd [1:NG];
  logic [DATW-1:0] mask_rd [1:NG];
  logic [DATW-1:0] g0_pend;
  logic [DATW-1:0] g0_mask;

  for (genvar g = 1; g <= NG; g++) begin : g_grp
    localparam int W = GRP_W[g];
    localparam int B = grp_base(g);
    logic [W-1:0] pend_w;
    logic [W-1:0] mask_w;
    logic         wr_p;
    logic         wr_m;

    assign wr_p = we_i && (addr_i == ADRW'(2 * g));
    assign wr_m = we_i && (addr_i == ADRW'(2 * g + 1));

    irq_grp_slice #(.W(W)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i[B +: W]),
      .wr_pend_i (wr_p),
      .wr_mask_i (wr_m),
      .wdata_i   (wdata_i[W-1:0]),
      .pend_o    (pend_w),
      .mask_o    (mask_w),
      .sum_o     (grp_sum[g])
    );

    assign pend_flat[B +: W] = pend_w;
    assign mask_flat[B +: W] = mask_w;
    assign pend_rd[g] = DATW'(pend_w);
    assign mask_rd[g] = DATW'(mask_w);
  end

  irq_root #(.NGRP(NG), .DW(DATW)) u_root (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sum_i     (grp_sum),
    .wr_mask_i (we_i && (addr_i == ADRW'(1))),
    .wdata_i   (wdata_i),
    .g0_pend_o (g0_pend),
    .g0_mask_o (g0_mask),
    .irq_no    (irq_no)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADRW'(0)) rdata_o = g0_pend;
    if (addr_i == ADRW'(1)) rdata_o = g0_mask;
    for (int g = 1; g <= NG; g++) begin
      if (addr_i == ADRW'(2 * g))     rdata_o = pend_rd[g];
      if (addr_i == ADRW'(2 * g + 1)) rdata_o = mask_rd[g];
    end
  end
endmodule

// File: rtl/irq_group_agg_chk.sv
module irq_group_agg_chk #(
  parameter int NS = 79,
  parameter int DATW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NS-1:0]   src_i,
  input logic            we_i,
  input logic [NS-1:0]   pend_flat,
  input logic [NS-1:0]   mask_flat,
  input logic [DATW-1:0] g0_pend,
  input logic [DATW-1:0] g0_mask,
  input logic            irq_no
);
  assert_pend_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~pend_flat & $past(src_i)) == '0));

  assert_pend_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_flat & ~$past(pend_flat) & ~$past(src_i)) == '0));

  assert_clear_needs_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ((~pend_flat & $past(pend_flat)) == '0));

  assert_mask_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mask_flat) && $stable(g0_mask)));

  assert_irq_raise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(g0_pend & g0_mask)) |=> !irq_no);

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> $past(|(g0_pend & g0_mask)));
endmodule

bind irq_group_agg irq_group_agg_chk #(.NS(NS), .DATW(DATW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .we_i      (we_i),
  .pend_flat (pend_flat),
  .mask_flat (mask_flat),
  .g0_pend   (g0_pend),
  .g0_mask   (g0_mask),
  .irq_no    (irq_no)
);

// File: tb/sim_irq_group_agg.sv
`timescale 1ns/1ps
module sim_irq_group_agg;
  localparam int NS = 79;
  localparam int GW [1:14] = '{1, 12, 7, 8, 3, 3, 5, 5, 5, 5, 4, 16, 4, 1};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic          we_i = 1'b0;
  logic [4:0]    addr_i = '0;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   rdata_o;
  logic          irq_no;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  bit mpend [NS];
  bit mmask [NS];
  bit [15:0] mg0mask;
  bit exp_irq_n;

  always #2.5 clk_i = ~clk_i;

  irq_group_agg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  function automatic int base_of(int g);
    int s = 0;
    for (int i = 1; i < g; i++) s += GW[i];
    return s;
  endfunction

  function automatic bit grp_active(int g);
    for (int b = 0; b < GW[g]; b++)
      if (mpend[base_of(g) + b] && mmask[base_of(g) + b]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] model_read(int a);
    logic [15:0] r = '0;
    if (a == 0) begin
      for (int g = 1; g <= 14; g++) r[g] = grp_active(g);
    end else if (a == 1) begin
      r = mg0mask;
    end else if (a <= 29) begin
      for (int b = 0; b < GW[a / 2]; b++)
        r[b] = (a % 2 == 0) ? mpend[base_of(a / 2) + b] : mmask[base_of(a / 2) + b];
    end
    return r;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R5";
    if (a == 1) return "R6";
    if (a >= 30) return "R8";
    return (a % 2 == 0) ? "R2" : "R4";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit any = 1'b0;
    for (int g = 1; g <= 14; g++) if (mg0mask[g] && grp_active(g)) any = 1'b1;
    for (int g = 1; g <= 14; g++)
      for (int b = 0; b < GW[g]; b++) begin
        int k = base_of(g) + b;
        bit clr = we_i && (int'(addr_i) == 2 * g) && wdata_i[b];
        mpend[k] = src_i[k] | (mpend[k] & !clr);
        if (we_i && int'(addr_i) == 2 * g + 1) mmask[k] = wdata_i[b];
      end
    if (we_i && addr_i == 5'd1) mg0mask = wdata_i & 16'h7FFE;
    exp_irq_n = !any;
  endtask

  // one cycle: drive after negedge, check read and irq, then advance model at posedge
  task automatic cyc(logic [NS-1:0] s, bit we, int a, logic [15:0] wd, string tag = "");
    src_i = s; we_i = we; addr_i = 5'(a); wdata_i = wd;
    #1;
    // R9: read data checked in the same cycle the address is applied
    check((tag == "") ? tag_of(a) : tag, rdata_o, model_read(a));
    check("R7", {15'd0, irq_no}, {15'd0, exp_irq_n});
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
  endtask

  function automatic logic [NS-1:0] one_src(int g, int b);
    logic [NS-1:0] v = '0;
    v[base_of(g) + b] = 1'b1;
    return v;
  endfunction

  initial begin
    for (int k = 0; k < NS; k++) begin mpend[k] = 0; mmask[k] = 0; end
    mg0mask = '0;
    exp_irq_n = 1'b1;
    repeat (3) @(negedge clk_i);
    // reset state: R4 R6 R7
    check("R7", {15'd0, irq_no}, 16'd1);
    for (int a = 0; a < 32; a++) begin
      addr_i = 5'(a); #1;
      check((a == 1) ? "R6" : ((a % 2 == 1) ? "R4" : tag_of(a)), rdata_o, 16'h0000);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: group 12 bit 9 reaches group-0 bit 12 only when enabled
    cyc(one_src(12, 9), 0, 0, 0);
    cyc('0, 0, 24, 0, "R1");
    cyc('0, 0, 0, 0, "R1");
    cyc('0, 1, 25, 16'h0200, "R4");
    cyc('0, 0, 0, 0, "R1");
    cyc('0, 1, 1, 16'hFFFF, "R6");
    cyc('0, 0, 1, 0, "R6");
    cyc('0, 0, 0, 0, "R7");
    cyc('0, 1, 0, 16'hFFFF, "R5");
    cyc('0, 0, 0, 0, "R5");
    // R3: clear while source high keeps it, clear after drop removes it
    cyc(one_src(12, 9), 1, 24, 16'h0200, "R3");
    cyc('0, 0, 24, 0, "R3");
    cyc('0, 1, 24, 16'h0000, "R3");
    cyc('0, 0, 24, 0, "R3");
    cyc('0, 1, 24, 16'h0200, "R3");
    cyc('0, 0, 24, 0, "R3");
    cyc('0, 0, 0, 0, "R7");
    // R8: unmapped writes are ignored
    cyc('0, 1, 30, 16'hFFFF, "R8");
    cyc('0, 1, 31, 16'hFFFF, "R8");
    cyc('0, 0, 31, 0, "R8");
    // R1: boundary groups 1 and 14
    for (int g = 1; g <= 14; g++) cyc('0, 1, 2 * g + 1, 16'hFFFF, "R4");
    cyc(one_src(1, 0), 0, 0, 0, "R1");
    cyc(one_src(14, 0), 0, 0, 0, "R1");
    cyc('0, 0, 0, 0, "R1");
    cyc('0, 1, 2, 16'hFFFF, "R3");
    cyc('0, 1, 28, 16'hFFFF, "R3");
    cyc('0, 0, 0, 0, "R1");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [NS-1:0] s;
      for (int k = 0; k < NS; k++) s[k] = ($urandom_range(19) == 0);
      cyc(s, $urandom_range(1), $urandom_range(31), 16'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule